// File: doc/BRIEF.md
# SMBus Configuration Slave Port

This block is the slave side of a System Management Bus link that lets an external host read and write a hub's byte-wide configuration register file. A bit-level bus engine, outside this block, turns SCL/SDA activity into single-cycle events: start (also used for a repeated start), stop, a received byte, and a request for the next byte to transmit. For each received byte the block answers with an acknowledge decision one cycle later. For each transmit request it returns the byte one cycle later.

Only block write and block read transfers are accepted. In a block write the command byte sets the start offset, the next byte gives a count, and the data bytes that follow go to consecutive offsets. In a block read the host first writes the command byte, then issues a repeated start and a read address. The block then returns a count followed by that many bytes from consecutive offsets. Two strap inputs, captured while reset is held, form the low bits of the slave address.

A status byte lives inside the block. One bit of it holds the upstream port disconnected until the host clears it, with no timeout. A second bit asks the register file to restore its defaults and clears itself when the file reports completion. Reads pass through fixed overlays for reserved and fuse-backed bits. Writes to read-only offsets are acknowledged and then dropped.

Top module: `smb_cfg_port`

## Requirements
- R1: After reset, ackValid, txValid, regWrEn and restoreReq are 0 and upstreamEnable is 0. The status byte at offset F8h reads 01h.
- R2: The 7-bit slave address is 1000 1 followed by strapHi and then strapLo, both captured while rst is high. Bit 0 of the address byte is 1 for a read. ackValid pulses one cycle after rxValid, and ackBit is 1 for an acknowledge. An address byte that does not match is not acknowledged, and neither is any byte after it until the next start.
- R3: In a block write the command byte sets the offset. A count from 1 to MAX_BLOCK is acknowledged. Each data byte is acknowledged, and one cycle after its rxValid it appears on regWrEn, regWrAddr and regWrData at the next consecutive offset.
- R4: A count of 0 or above MAX_BLOCK is not acknowledged, and no later byte is acknowledged until the next start. Data bytes beyond the count are not acknowledged and are not written.
- R5: A block read consists of a write address, a command byte, a repeated start and a read address. The first transmitted byte is MAX_BLOCK. The next MAX_BLOCK bytes come from consecutive offsets starting at the command offset. Any further request returns FFh. txValid pulses one cycle after txReq.
- R6: A read address that arrives without a command byte earlier in the same transfer is not acknowledged, and transmit requests then return FFh.
- R7: Bit 0 of F8h, the configuration-active bit, is 1 from reset. Writing 1 to it clears it, and writing 0 has no effect. upstreamEnable is 1 exactly when the configuration-active bit is 0 and no restore is pending.
- R8: Writing 1 to bit 1 of F8h raises restoreReq from the next cycle and sets the configuration-active bit again. Bit 1 reads 1 and restoreReq stays high until restoreDone is seen, after which both clear. Writing 0 to bit 1 has no effect. While a restore is pending, writing 1 to bit 0 does not clear the configuration-active bit.
- R9: Read overlays apply. Bits 7:2 of F8h read 0. Bit 4 of offset 05h reads 1. The low FUSE_W bits of offset 25h read as the stored bit OR the matching fuseCfg bit.
- R10: Writable offsets are 00h to 0Bh, 20h to 2Eh, 30h to CFh, and F0h. A data byte aimed at any other offset except F8h is acknowledged but produces no regWrEn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; straps are captured while it is high |
| strapHi | input | 1 | Strap giving address bit 1 |
| strapLo | input | 1 | Strap giving address bit 0 |
| fuseCfg | input | FUSE_W | Fuse bits ORed into offset 25h on read |
| busStart | input | 1 | Start or repeated start seen on the bus |
| busStop | input | 1 | Stop seen on the bus |
| rxValid | input | 1 | A received byte is on rxByte |
| rxByte | input | 8 | Received byte |
| txReq | input | 1 | The bus engine needs the next byte to send |
| ackValid | output | 1 | Acknowledge decision is valid |
| ackBit | output | 1 | 1 means acknowledge, 0 means not acknowledged |
| txValid | output | 1 | txByte is valid |
| txByte | output | 8 | Byte to transmit |
| regRdAddr | output | 8 | Register file read offset |
| regRdData | input | 8 | Register file read data, combinational from regRdAddr |
| regWrEn | output | 1 | Register file write strobe |
| regWrAddr | output | 8 | Register file write offset |
| regWrData | output | 8 | Register file write data |
| restoreReq | output | 1 | Asks the register file to reload its defaults |
| restoreDone | input | 1 | Register file finished reloading defaults |
| upstreamEnable | output | 1 | Upstream port may connect |

## Verification
Block writes are tried with several counts. Counts inside the allowed range separate correct offset stepping from off-by-one errors. A count of zero, an oversized count and a surplus data byte show whether the count check and the mute state keep bytes out of the register file. Block reads are tried over plain offsets, over 05h, 25h and F8h, and past the returned count, which separates the read overlays and the fill byte from plain read-through. A mismatched strap address, a read with no command byte and writes to read-only offsets test the paths that must stay silent or leave the register file untouched. Writes of 00h, 01h and 02h to the status byte, including a write during a pending restore, separate the write-1-to-clear behaviour, the self-clearing restore and the upstream hold from one another.

// File: rtl/smbcfg_pkg.sv
package smbcfg_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_CMD, S_CNT, S_WDATA, S_RCNT, S_RDATA, S_MUTE
  } busState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadPtr;
    logic writeByte;
    logic sendCount;
    logic sendData;
    logic sendFill;
  } dpStrobe_t;

  localparam logic [7:0] STATUS_OFS = 8'hF8;
  localparam logic [7:0] CFG_OFS    = 8'h05;
  localparam logic [7:0] CFG3_OFS   = 8'h25;
  localparam logic [7:0] FILL_BYTE  = 8'hFF;

  function automatic logic offsetWritable(input logic [7:0] a);
    return (a < 8'h0C) || (a >= 8'h20 && a <= 8'h2E) ||
           (a >= 8'h30 && a <= 8'hCF) || (a == 8'hF0);
  endfunction

endpackage

// File: rtl/smbcfg_ctrl.sv
module smbcfg_ctrl
  import smbcfg_pkg::*;
#(
  parameter int MAX_BLOCK = 32
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      strapHi,
  input  logic      strapLo,
  input  logic      busStart,
  input  logic      busStop,
  input  logic      rxValid,
  input  logic [7:0] rxByte,
  input  logic      txReq,
  output logic      ackValid,
  output logic      ackBit,
  output dpStrobe_t stb
);
  localparam int CNT_W = $clog2(MAX_BLOCK + 1);
  localparam logic [7:0] MAX_BYTE = 8'(MAX_BLOCK);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_BLOCK);

  busState_t state, stateNxt;
  logic [1:0] strapQ;
  logic [6:0] myAddr;
  logic cmdSeen, cmdNxt, ackNow, addrHit;
  logic [CNT_W-1:0] remain, remNxt;

  assign myAddr  = {5'b10001, strapQ};
  assign addrHit = (rxByte[7:1] == myAddr);

  always_comb begin
    stb      = '0;
    stateNxt = state;
    cmdNxt   = cmdSeen;
    remNxt   = remain;
    ackNow   = 1'b0;
    if (busStop) begin
      stateNxt = S_IDLE;
      cmdNxt   = 1'b0;
    end else if (busStart) begin
      stateNxt = S_ADDR;
    end else if (rxValid) begin
      case (state)
        S_ADDR: begin
          if (addrHit && !rxByte[0]) begin
            ackNow = 1'b1; stateNxt = S_CMD;
          end else if (addrHit && cmdSeen) begin
            ackNow = 1'b1; stateNxt = S_RCNT;
          end else begin
            stateNxt = S_MUTE;
          end
        end
        S_CMD: begin
          ackNow = 1'b1; stb.loadPtr = 1'b1; cmdNxt = 1'b1; stateNxt = S_CNT;
        end
        S_CNT: begin
          if (rxByte != 8'd0 && rxByte <= MAX_BYTE) begin
            ackNow = 1'b1; remNxt = rxByte[CNT_W-1:0]; stateNxt = S_WDATA;
          end else begin
            stateNxt = S_MUTE;
          end
        end
        S_WDATA: begin
          if (remain != '0) begin
            ackNow = 1'b1; stb.writeByte = 1'b1; remNxt = remain - 1'b1;
          end else begin
            stateNxt = S_MUTE;
          end
        end
        default: ackNow = 1'b0;
      endcase
    end else if (txReq) begin
      case (state)
        S_RCNT: begin
          stb.sendCount = 1'b1; remNxt = MAX_CNT; stateNxt = S_RDATA;
        end
        S_RDATA: begin
          if (remain != '0) begin
            stb.sendData = 1'b1; remNxt = remain - 1'b1;
          end else begin
            stb.sendFill = 1'b1;
          end
        end
        default: stb.sendFill = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      strapQ   <= {strapHi, strapLo};
      state    <= S_IDLE;
      cmdSeen  <= 1'b0;
      remain   <= '0;
      ackValid <= 1'b0;
      ackBit   <= 1'b0;
    end else begin
      state    <= stateNxt;
      cmdSeen  <= cmdNxt;
      remain   <= remNxt;
      ackValid <= rxValid;
      ackBit   <= rxValid & ackNow;
    end
  end

  // R4
  remain_bound_chk: assert property (@(posedge clk) disable iff (rst)
    remain <= MAX_CNT);

  // R2
  ack_follows_rx_chk: assert property (@(posedge clk) disable iff (rst)
    ackValid |-> $past(rxValid));

  // R6
  read_needs_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_RCNT) |-> cmdSeen);

endmodule

// File: rtl/smbcfg_dp.sv
module smbcfg_dp
  import smbcfg_pkg::*;
#(
  parameter int MAX_BLOCK = 32,
  parameter int FUSE_W    = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         stb,
  input  logic [7:0]        rxByte,
  input  logic [FUSE_W-1:0] fuseCfg,
  input  logic [7:0]        regRdData,
  input  logic              restoreDone,
  output logic [7:0]        regRdAddr,
  output logic              regWrEn,
  output logic [7:0]        regWrAddr,
  output logic [7:0]        regWrData,
  output logic              txValid,
  output logic [7:0]        txByte,
  output logic              restoreReq,
  output logic              upstreamEnable
);
  localparam logic [7:0] MAX_BYTE = 8'(MAX_BLOCK);

  logic [7:0] ptr, readView;
  logic cfgActive, softRst;

  assign regRdAddr      = ptr;
  assign restoreReq     = softRst;
  assign upstreamEnable = !cfgActive && !softRst;

  always_comb begin
    case (ptr)
      STATUS_OFS: readView = {6'b0, softRst, cfgActive};
      CFG_OFS:    readView = regRdData | 8'h10;
      CFG3_OFS:   readView = regRdData | 8'(fuseCfg);
      default:    readView = regRdData;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr       <= '0;
      regWrEn   <= 1'b0;
      regWrAddr <= '0;
      regWrData <= '0;
      txValid   <= 1'b0;
      txByte    <= FILL_BYTE;
      cfgActive <= 1'b1;
      softRst   <= 1'b0;
    end else begin
      regWrEn <= 1'b0;
      txValid <= 1'b0;
      if (softRst && restoreDone) softRst <= 1'b0;
      if (stb.loadPtr) ptr <= rxByte;
      if (stb.writeByte) begin
        ptr <= ptr + 8'd1;
        if (ptr == STATUS_OFS) begin
          if (rxByte[1]) begin
            softRst   <= 1'b1;
            cfgActive <= 1'b1;
          end else if (rxByte[0] && !softRst) begin
            cfgActive <= 1'b0;
          end
        end else if (offsetWritable(ptr)) begin
          regWrEn   <= 1'b1;
          regWrAddr <= ptr;
          regWrData <= rxByte;
        end
      end
      if (stb.sendCount) begin
        txValid <= 1'b1; txByte <= MAX_BYTE;
      end
      if (stb.sendData) begin
        txValid <= 1'b1; txByte <= readView; ptr <= ptr + 8'd1;
      end
      if (stb.sendFill) begin
        txValid <= 1'b1; txByte <= FILL_BYTE;
      end
    end
  end

  // R7
  cfg_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cfgActive) |-> $past(stb.writeByte && ptr == STATUS_OFS && rxByte[0]));

  // R8
  restore_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(softRst) |-> $past(restoreDone));

  // R8
  restore_holds_active_chk: assert property (@(posedge clk) disable iff (rst)
    softRst |-> cfgActive);

  // R10
  ro_write_chk: assert property (@(posedge clk) disable iff (rst)
    regWrEn |-> offsetWritable(regWrAddr));

  // R5
  tx_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    txValid |-> $past(stb.sendCount || stb.sendData || stb.sendFill));

endmodule

// File: rtl/smb_cfg_port.sv
module smb_cfg_port
  import smbcfg_pkg::*;
#(
  parameter int MAX_BLOCK = 32,
  parameter int FUSE_W    = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strapHi,
  input  logic              strapLo,
  input  logic [FUSE_W-1:0] fuseCfg,
  input  logic              busStart,
  input  logic              busStop,
  input  logic              rxValid,
  input  logic [7:0]        rxByte,
  input  logic              txReq,
  output logic              ackValid,
  output logic              ackBit,
  output logic              txValid,
  output logic [7:0]        txByte,
  output logic [7:0]        regRdAddr,
  input  logic [7:0]        regRdData,
  output logic              regWrEn,
  output logic [7:0]        regWrAddr,
  output logic [7:0]        regWrData,
  output logic              restoreReq,
  input  logic              restoreDone,
  output logic              upstreamEnable
);
  dpStrobe_t stb;

  smbcfg_ctrl #(.MAX_BLOCK(MAX_BLOCK)) u_ctrl (
    .clk(clk), .rst(rst), .strapHi(strapHi), .strapLo(strapLo),
    .busStart(busStart), .busStop(busStop), .rxValid(rxValid),
    .rxByte(rxByte), .txReq(txReq), .ackValid(ackValid),
    .ackBit(ackBit), .stb(stb)
  );

  smbcfg_dp #(.MAX_BLOCK(MAX_BLOCK), .FUSE_W(FUSE_W)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .rxByte(rxByte), .fuseCfg(fuseCfg),
    .regRdData(regRdData), .restoreDone(restoreDone), .regRdAddr(regRdAddr),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .txValid(txValid), .txByte(txByte), .restoreReq(restoreReq),
    .upstreamEnable(upstreamEnable)
  );

endmodule

// File: tb/smb_cfg_port_tb.sv
`timescale 1ns/1ps
module smb_cfg_port_tb;
  localparam int MAXB = 4;
  localparam int FW   = 5;

  logic clk = 0, rst = 1;
  logic strapHi, strapLo;
  logic [FW-1:0] fuseCfg;
  logic busStart = 0, busStop = 0, rxValid = 0, txReq = 0, restoreDone = 0;
  logic [7:0] rxByte = 0;
  logic ackValid, ackBit, txValid, regWrEn, restoreReq, upstreamEnable;
  logic [7:0] txByte, regRdAddr, regRdData, regWrAddr, regWrData;

  always #2.5 clk = ~clk;

  smb_cfg_port #(.MAX_BLOCK(MAXB), .FUSE_W(FW)) u_dut (
    .clk(clk), .rst(rst), .strapHi(strapHi), .strapLo(strapLo),
    .fuseCfg(fuseCfg), .busStart(busStart), .busStop(busStop),
    .rxValid(rxValid), .rxByte(rxByte), .txReq(txReq),
    .ackValid(ackValid), .ackBit(ackBit), .txValid(txValid),
    .txByte(txByte), .regRdAddr(regRdAddr), .regRdData(regRdData),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .restoreReq(restoreReq), .restoreDone(restoreDone),
    .upstreamEnable(upstreamEnable)
  );

  int checks = 0, errors = 0;
  bit done = 0, monOn = 0;

  // environment register file, driven only by the DUT's write port
  logic [7:0] envMem [256];
  int rcnt = 0;
  assign regRdData = envMem[regRdAddr];

  // bench reference model
  logic [7:0] refMem [256];
  bit mActive = 1, mSoft = 0, expUp = 0;
  bit expWrNow = 0;
  logic [7:0] expWrAddr = 0, expWrData = 0;

  function automatic logic [7:0] dflt(input int i);
    return 8'(i) ^ 8'h5A;
  endfunction

  function automatic bit benchWritable(input logic [7:0] a);
    if (a <= 8'h0B) return 1;
    if (a >= 8'h20 && a <= 8'h2E) return 1;
    if (a >= 8'h30 && a <= 8'hCF) return 1;
    return a == 8'hF0;
  endfunction

  function automatic logic [7:0] refView(input logic [7:0] a);
    if (a == 8'hF8) return {6'b0, mSoft, mActive};
    if (a == 8'h05) return refMem[a] | 8'h10;
    if (a == 8'h25) return refMem[a] | {3'b0, fuseCfg};
    return refMem[a];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, expv);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin envMem[i] = dflt(i); refMem[i] = dflt(i); end
  end

  always @(negedge clk) begin
    if (restoreDone) restoreDone = 0;
    else if (restoreReq) begin
      rcnt = rcnt + 1;
      if (rcnt == 40) begin
        restoreDone = 1; rcnt = 0;
        for (int i = 0; i < 256; i++) envMem[i] = dflt(i);
      end
    end
    if (regWrEn) envMem[regWrAddr] = regWrData;
  end

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #2;
    if (monOn) begin
      chk(regWrEn === expWrNow, "R10 write strobe", regWrEn, expWrNow);
      if (regWrEn && expWrNow)
        chk(regWrAddr === expWrAddr && regWrData === expWrData, "R3 write addr/data",
            {regWrAddr, regWrData}, {expWrAddr, expWrData});
      chk(upstreamEnable === expUp, "R7 upstreamEnable", upstreamEnable, expUp);
    end
  end

  task automatic pStart(); busStart = 1; @(negedge clk); busStart = 0; endtask
  task automatic pStop();  busStop = 1;  @(negedge clk); busStop = 0;  endtask

  task automatic sendByte(input logic [7:0] b, input bit expAck, input bit expWr,
                          input logic [7:0] wAddr, input string tag);
    rxValid = 1; rxByte = b; expWrNow = expWr; expWrAddr = wAddr; expWrData = b;
    @(negedge clk);
    rxValid = 0; expWrNow = 0;
    chk(ackValid === 1'b1 && ackBit === expAck, tag, {ackValid, ackBit}, {1'b1, expAck});
  endtask

  task automatic recvByte(input logic [7:0] expv, input string tag);
    txReq = 1;
    @(negedge clk);
    txReq = 0;
    chk(txValid === 1'b1 && txByte === expv, tag, {txValid, txByte}, {1'b1, expv});
  endtask

  task automatic hostWrite(input logic [7:0] off, input logic [7:0] d[$], input string tag);
    pStart();
    sendByte(8'h8C, 1, 0, 0, tag);
    sendByte(off, 1, 0, 0, tag);
    sendByte(8'(d.size()), 1, 0, 0, tag);
    foreach (d[i]) begin
      logic [7:0] a;
      bit w;
      a = off + 8'(i);
      w = benchWritable(a);
      if (a == 8'hF8) begin
        if (d[i][1]) begin mSoft = 1; mActive = 1; end
        else if (d[i][0] && !mSoft) mActive = 0;
        expUp = !mActive && !mSoft;
      end else if (w) refMem[a] = d[i];
      sendByte(d[i], 1, w, a, tag);
    end
    pStop();
  endtask

  task automatic hostRead(input logic [7:0] off, input int n, input bit extra, input string tag);
    pStart();
    sendByte(8'h8C, 1, 0, 0, tag);
    sendByte(off, 1, 0, 0, tag);
    pStart();
    sendByte(8'h8D, 1, 0, 0, tag);
    recvByte(8'(MAXB), tag);
    for (int i = 0; i < n; i++) recvByte(refView(off + 8'(i)), tag);
    if (extra) recvByte(8'hFF, tag);
    pStop();
  endtask

  initial begin
    strapHi = 1; strapLo = 0; fuseCfg = 5'b00101;
    repeat (4) @(negedge clk);
    rst = 0;
    strapHi = 0; strapLo = 0;  // captured values must persist
    @(negedge clk);
    monOn = 1;
    chk(ackValid === 0 && txValid === 0 && regWrEn === 0 && restoreReq === 0,
        "R1 idle outputs", {ackValid, txValid, regWrEn, restoreReq}, 0);
    chk(upstreamEnable === 0, "R1 upstream held", upstreamEnable, 0);
    hostRead(8'hF8, 1, 0, "R1 status after reset");

    // R2: address with wrong strap bit, then muted
    pStart();
    sendByte(8'h8E, 0, 0, 0, "R2 wrong address");
    sendByte(8'h02, 0, 0, 0, "R2 muted after miss");
    pStop();

    // R3 / R5 / R9
    hostWrite(8'h02, '{8'hA1, 8'hB2, 8'hC3, 8'h00}, "R3 block write");
    hostRead(8'h02, MAXB, 1, "R5 block read with fill");
    hostWrite(8'h25, '{8'h00}, "R3 write cfg3");
    hostRead(8'h25, 1, 0, "R9 fuse overlay");

    // R4
    pStart();
    sendByte(8'h8C, 1, 0, 0, "R4 addr");
    sendByte(8'h30, 1, 0, 0, "R4 cmd");
    sendByte(8'h00, 0, 0, 0, "R4 zero count");
    sendByte(8'h77, 0, 0, 0, "R4 muted data");
    pStop();
    pStart();
    sendByte(8'h8C, 1, 0, 0, "R4 addr");
    sendByte(8'h30, 1, 0, 0, "R4 cmd");
    sendByte(8'(MAXB + 1), 0, 0, 0, "R4 oversize count");
    pStop();
    pStart();
    sendByte(8'h8C, 1, 0, 0, "R4 addr");
    sendByte(8'h31, 1, 0, 0, "R4 cmd");
    sendByte(8'h01, 1, 0, 0, "R4 count one");
    refMem[8'h31] = 8'h66;
    sendByte(8'h66, 1, 1, 8'h31, "R4 data in count");
    sendByte(8'h77, 0, 0, 0, "R4 surplus data");
    pStop();
    hostRead(8'h30, 3, 0, "R4 readback");

    // R10
    hostWrite(8'h0E, '{8'h11, 8'h22}, "R10 read-only write");
    hostRead(8'h0E, 2, 0, "R10 read-only unchanged");
    hostWrite(8'hF0, '{8'h99}, "R10 writable F0");
    hostRead(8'hF0, 1, 0, "R10 F0 readback");

    // R6
    pStart();
    sendByte(8'h8D, 0, 0, 0, "R6 read without command");
    recvByte(8'hFF, "R6 fill byte");
    pStop();

    // R7 / R8
    hostWrite(8'hF8, '{8'h00}, "R7 write zero");
    chk(restoreReq === 0, "R8 zero leaves restore idle", restoreReq, 0);
    hostRead(8'hF8, 1, 0, "R7 still active");
    hostWrite(8'hF8, '{8'h01}, "R7 clear active");
    chk(upstreamEnable === 1, "R7 upstream released", upstreamEnable, 1);
    hostRead(8'hF8, 1, 0, "R9 status cleared");
    hostWrite(8'hF8, '{8'h02}, "R8 soft restore");
    chk(restoreReq === 1, "R8 restore requested", restoreReq, 1);
    hostRead(8'hF8, 1, 0, "R8 pending status");
    hostWrite(8'hF8, '{8'h01}, "R8 clear blocked while pending");
    hostRead(8'hF8, 1, 0, "R8 still pending");
    repeat (60) @(negedge clk);
    mSoft = 0;
    for (int i = 0; i < 256; i++) refMem[i] = dflt(i);
    chk(restoreReq === 0, "R8 restore self-cleared", restoreReq, 0);
    hostRead(8'hF8, 1, 0, "R8 status after restore");
    hostRead(8'h02, 2, 0, "R8 defaults restored");

    monOn = 0;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule